// File: doc/BRIEF.md
# Two-Cycle Learn Command Sequencer

This block takes a host "learn" instruction that arrives on a command bus over two consecutive clock cycles. It copies the selected comparand word, or the selected even/odd pair of comparand words, into the search array at the slot held by the next-free pointer. It then emits a matching write cycle on the external result SRAM. The first command cycle carries the opcode, the comparand pair index and three high SRAM address bits. The second cycle repeats the opcode and the index and says whether the entry is a single word or a double word. In the third cycle the host idles the command bus. A new instruction may begin in the cycle after that.

The comparand register file sits outside the block. The sequencer presents the pair index on a read port and samples both words in the second command cycle. Each word it writes has its occupancy bit forced to one. After every array write it pulses a strobe so that the next-free pointer logic can advance. A learn is dropped without any write in three cases: this device is not the chosen learner, the table is configured for quad-width entries, or the second cycle does not match the first. The SRAM write is held back by a fixed number of cycles so that it lines up with the search-to-SRAM-read latency.

Top module: `learn_seq`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are idle: both array write strobes are 0, all array data and address outputs are 0, the pointer strobe is 0, `sram_ce_n` and `sram_we_n` are 1, `sram_addr` is 0, and `cmp_pair` is 0.
- R2: A well-formed learn has a first cycle with `cmd_vld`=1, `cmd[1:0]`=2'b11 and index `cmd[5:2]`. It has a second cycle with the same opcode and index, and with `cmd[6]`=0 (single word). Such a learn asserts only `arr_we_even` for exactly one cycle, in the cycle after the second command cycle. `arr_addr` equals the `nfa` sampled in the second cycle. `arr_wdata_even` equals `cmp_even_data` from the second cycle with bit 0 forced to 1.
- R3: With `cmd[6]`=1 in the second cycle (double word), both strobes assert in that same cycle. `arr_addr` is `nfa` with bit 0 cleared. Each data output carries its comparand word with bit 0 forced to 1.
- R4: `cmp_pair` shows the index `cmd[5:2]` captured in an accepted first cycle, from the following cycle onward.
- R5: `nfa_upd` pulses high for exactly one cycle, in the cycle after each array write.
- R6: Each array write is paired with one SRAM write. `sram_ce_n` and `sram_we_n` are both low for one cycle, `SRCH_LAT` cycles after the second command cycle. `sram_addr` is `{cmd[8:6] of the first cycle, array address zero-extended}`.
- R7: When `tbl_mode` (00 = single, 01 = double, 10 = quad, 11 = reserved) is 10 or 11 in the second cycle, the learn produces no array write, no SRAM write and no pointer strobe.
- R8: When `learn_sel` is 0 in the second cycle, the learn produces no array write, no SRAM write and no pointer strobe.
- R9: A second cycle with `cmd_vld`=0, an opcode other than 2'b11, or a different index aborts without any write. That cycle is not taken as a new first cycle, and a first cycle in the next clock is accepted.
- R10: While idle, commands with an opcode other than 2'b11 are ignored. A command presented in the third cycle of a learn is ignored.
- R11: Learns issued back to back, each starting right after the previous third cycle, each produce their own array write and their own delayed SRAM write, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Command bus valid |
| cmd | input | 9 | Command bus: opcode [1:0], index [5:2], high SRAM bits / width flag [8:6] |
| learn_sel | input | 1 | This device is the chosen learner |
| tbl_mode | input | 2 | Table entry width configuration |
| nfa | input | 14 | Next-free array address |
| cmp_pair | output | 4 | Comparand pair index for the read port |
| cmp_even_data | input | 68 | Even comparand word of the indexed pair |
| cmp_odd_data | input | 68 | Odd comparand word of the indexed pair |
| arr_we_even | output | 1 | Array write strobe, even word |
| arr_we_odd | output | 1 | Array write strobe, odd word |
| arr_addr | output | 14 | Array write address (base word) |
| arr_wdata_even | output | 68 | Array write data, even word |
| arr_wdata_odd | output | 68 | Array write data, odd word |
| nfa_upd | output | 1 | Next-free pointer advance strobe |
| sram_addr | output | 22 | External SRAM address |
| sram_ce_n | output | 1 | External SRAM chip enable, active low |
| sram_we_n | output | 1 | External SRAM write enable, active low |

## Verification
Single-word and double-word learns are applied with even, odd and all-ones next-free values. This separates the base-address clearing from plain pass-through, and comparand data with bit 0 at zero exposes a missing occupancy force. Rejected learns (quad mode, reserved mode, learner deselected) and malformed second cycles (opcode, index, valid dropped) show whether a write can leak from a decoded but refused command. Back-to-back learns, with the SRAM delay longer than the instruction spacing, show whether in-flight SRAM writes are kept apart and in order. Commands sent while idle or during the trailing cycle show whether such commands are ignored.

// File: rtl/learn_pkg.sv
package learn_pkg;

    // Command bus field positions (both command cycles share this layout)
    localparam int OP_LSB   = 0;
    localparam int OP_W     = 2;
    localparam int IDX_LSB  = 2;
    localparam int HI_LSB   = 6;
    localparam int WIDE_BIT = 6;

    localparam logic [OP_W-1:0] OP_LEARN = 2'b11;

    // Table configuration codes
    localparam logic [1:0] MODE_X68  = 2'b00;
    localparam logic [1:0] MODE_X136 = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_TAIL = 2'd2
    } lrn_st_e;

endpackage

// File: rtl/learn_cmd_decode.sv
module learn_cmd_decode
    import learn_pkg::*;
#(
    parameter int CMD_W = 9,
    parameter int IDX_W = 4,
    parameter int HI_W  = 3
) (
    input  logic             cmd_vld,
    input  logic [CMD_W-1:0] cmd,
    output logic             is_learn,
    output logic [IDX_W-1:0] idx,
    output logic [HI_W-1:0]  hi,
    output logic             wide
);

    assign is_learn = cmd_vld && (cmd[OP_LSB +: OP_W] == OP_LEARN);
    assign idx      = cmd[IDX_LSB +: IDX_W];
    assign hi       = cmd[HI_LSB +: HI_W];
    assign wide     = cmd[WIDE_BIT];

endmodule

// File: rtl/learn_word_fmt.sv
module learn_word_fmt #(
    parameter int DATA_W = 68,
    parameter int LANES  = 2
) (
    input  logic [LANES-1:0][DATA_W-1:0] raw,
    output logic [LANES-1:0][DATA_W-1:0] fmt
);

    // Every learned word is marked occupied in bit 0
    localparam logic [DATA_W-1:0] OCC_MASK = DATA_W'(1);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign fmt[g] = raw[g] | OCC_MASK;
    end

endmodule

// File: rtl/learn_sram_delay.sv
module learn_sram_delay #(
    parameter int AW  = 22,
    parameter int LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [AW-1:0] in_addr,
    output logic          out_vld,
    output logic [AW-1:0] out_addr
);

    logic          vld_q [LAT];
    logic [AW-1:0] adr_q [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < LAT; s++) begin
                vld_q[s] <= 1'b0;
                adr_q[s] <= '0;
            end
        end else begin
            vld_q[0] <= in_vld;
            adr_q[0] <= in_addr;
            for (int s = 1; s < LAT; s++) begin
                vld_q[s] <= vld_q[s-1];
                adr_q[s] <= adr_q[s-1];
            end
        end
    end

    assign out_vld  = vld_q[LAT-1];
    assign out_addr = adr_q[LAT-1];

endmodule

// File: rtl/learn_seq.sv
module learn_seq
    import learn_pkg::*;
#(
    parameter int CMD_W    = 9,
    parameter int IDX_W    = 4,
    parameter int HI_W     = 3,
    parameter int DATA_W   = 68,
    parameter int NFA_W    = 14,
    parameter int SRAM_AW  = 22,
    parameter int SRCH_LAT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_vld,
    input  logic [CMD_W-1:0]   cmd,
    input  logic               learn_sel,
    input  logic [1:0]         tbl_mode,
    input  logic [NFA_W-1:0]   nfa,
    output logic [IDX_W-1:0]   cmp_pair,
    input  logic [DATA_W-1:0]  cmp_even_data,
    input  logic [DATA_W-1:0]  cmp_odd_data,
    output logic               arr_we_even,
    output logic               arr_we_odd,
    output logic [NFA_W-1:0]   arr_addr,
    output logic [DATA_W-1:0]  arr_wdata_even,
    output logic [DATA_W-1:0]  arr_wdata_odd,
    output logic               nfa_upd,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               sram_ce_n,
    output logic               sram_we_n
);

    localparam int SRAM_LO_W = SRAM_AW - HI_W;
    localparam int LANES     = 2;

    typedef struct packed {
        lrn_st_e           st;
        logic [IDX_W-1:0]  idx;
        logic [HI_W-1:0]   hi;
        logic              we_e;
        logic              we_o;
        logic [NFA_W-1:0]  addr;
        logic [DATA_W-1:0] wd_e;
        logic [DATA_W-1:0] wd_o;
        logic              upd;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                          dec_learn;
    logic [IDX_W-1:0]              dec_idx;
    logic [HI_W-1:0]               dec_hi;
    logic                          dec_wide;
    logic [LANES-1:0][DATA_W-1:0]  cmp_raw;
    logic [LANES-1:0][DATA_W-1:0]  cmp_fmt;
    logic                          push_vld;
    logic [SRAM_AW-1:0]            push_addr;
    logic                          dly_vld;
    logic [SRAM_AW-1:0]            dly_addr;
    logic                          mode_ok;
    logic [NFA_W-1:0]              base_addr;

    learn_cmd_decode #(
        .CMD_W (CMD_W),
        .IDX_W (IDX_W),
        .HI_W  (HI_W)
    ) u_dec (
        .cmd_vld  (cmd_vld),
        .cmd      (cmd),
        .is_learn (dec_learn),
        .idx      (dec_idx),
        .hi       (dec_hi),
        .wide     (dec_wide)
    );

    assign cmp_raw = {cmp_odd_data, cmp_even_data};

    learn_word_fmt #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_fmt (
        .raw (cmp_raw),
        .fmt (cmp_fmt)
    );

    assign mode_ok   = (tbl_mode == MODE_X68) || (tbl_mode == MODE_X136);
    assign base_addr = dec_wide ? {nfa[NFA_W-1:1], 1'b0} : nfa;

    always_comb begin
        seq_d      = seq_q;
        seq_d.we_e = 1'b0;
        seq_d.we_o = 1'b0;
        seq_d.addr = '0;
        seq_d.wd_e = '0;
        seq_d.wd_o = '0;
        seq_d.upd  = seq_q.we_e;
        push_vld   = 1'b0;
        push_addr  = '0;

        unique case (seq_q.st)
            ST_IDLE: begin
                if (dec_learn) begin
                    seq_d.st  = ST_HOLD;
                    seq_d.idx = dec_idx;
                    seq_d.hi  = dec_hi;
                end
            end
            ST_HOLD: begin
                if (dec_learn && (dec_idx == seq_q.idx)) begin
                    seq_d.st = ST_TAIL;
                    if (learn_sel && mode_ok) begin
                        seq_d.we_e = 1'b1;
                        seq_d.we_o = dec_wide;
                        seq_d.addr = base_addr;
                        seq_d.wd_e = cmp_fmt[0];
                        seq_d.wd_o = dec_wide ? cmp_fmt[1] : '0;
                        push_vld   = 1'b1;
                        push_addr  = {seq_q.hi, SRAM_LO_W'(base_addr)};
                    end
                end else begin
                    seq_d.st = ST_IDLE;
                end
            end
            ST_TAIL: seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    learn_sram_delay #(
        .AW  (SRAM_AW),
        .LAT (SRCH_LAT)
    ) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (push_vld),
        .in_addr  (push_addr),
        .out_vld  (dly_vld),
        .out_addr (dly_addr)
    );

    assign cmp_pair       = seq_q.idx;
    assign arr_we_even    = seq_q.we_e;
    assign arr_we_odd     = seq_q.we_o;
    assign arr_addr       = seq_q.addr;
    assign arr_wdata_even = seq_q.wd_e;
    assign arr_wdata_odd  = seq_q.wd_o;
    assign nfa_upd        = seq_q.upd;
    assign sram_addr      = dly_addr;
    assign sram_ce_n      = ~dly_vld;
    assign sram_we_n      = ~dly_vld;

endmodule

// File: rtl/learn_seq_chk.sv
module learn_seq_chk #(
    parameter int PEND_W = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_vld,
    input logic [1:0] cmd_op,
    input logic       learn_sel,
    input logic [1:0] tbl_mode,
    input logic       arr_we_even,
    input logic       arr_we_odd,
    input logic       arr_addr0,
    input logic       wd_even0,
    input logic       wd_odd0,
    input logic       nfa_upd,
    input logic       sram_ce_n,
    input logic       sram_we_n
);

    // Array writes not yet matched by an SRAM write
    logic [PEND_W-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_q + PEND_W'(arr_we_even) - PEND_W'(!sram_we_n);
        end
    end

    a_r2_even_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_even |-> wd_even0);

    a_r3_pair_on_even_base: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_odd |-> (arr_we_even && !arr_addr0 && wd_odd0));

    a_r5_upd_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_even |=> nfa_upd);

    a_r5_upd_has_write: assert property (@(posedge clk) disable iff (!rst_n)
        nfa_upd |-> $past(arr_we_even));

    a_r6_we_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n);

    a_r6_ce_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> !sram_we_n);

    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> sram_we_n);

    a_r6_sram_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> ((pend_q != '0) || arr_we_even));

    a_r7_not_in_wide_modes: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_even |-> ($past(tbl_mode[1]) == 1'b0));

    a_r8_needs_selection: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_even |-> $past(learn_sel));

    a_r9_needs_learn_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_even |-> $past(cmd_vld && (cmd_op == 2'b11)));

endmodule

bind learn_seq learn_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_vld     (cmd_vld),
    .cmd_op      (cmd[1:0]),
    .learn_sel   (learn_sel),
    .tbl_mode    (tbl_mode),
    .arr_we_even (arr_we_even),
    .arr_we_odd  (arr_we_odd),
    .arr_addr0   (arr_addr[0]),
    .wd_even0    (arr_wdata_even[0]),
    .wd_odd0     (arr_wdata_odd[0]),
    .nfa_upd     (nfa_upd),
    .sram_ce_n   (sram_ce_n),
    .sram_we_n   (sram_we_n)
);

// File: tb/tb_learn_seq.sv
module tb_learn_seq;

    localparam int CLK_P    = 10;
    localparam int SRCH_LAT = 4;
    localparam int DW       = 68;
    localparam int NW       = 14;
    localparam int SW       = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_vld_i = 1'b0;
    logic [8:0]    cmd_i = '0;
    logic          sel_i = 1'b1;
    logic [1:0]    mode_i = 2'b00;
    logic [NW-1:0] nfa_i = '0;
    logic [3:0]    cmp_pair;
    logic [DW-1:0] cmp_e, cmp_o;
    logic          we_e, we_o, upd, sce_n, swe_n;
    logic [NW-1:0] aaddr;
    logic [DW-1:0] wde, wdo;
    logic [SW-1:0] saddr;
    logic [DW-1:0] salt = '0;

    int    vectors = 0;
    int    fails = 0;
    int    cyc = 0;
    string phase = "R1";

    always #(CLK_P/2) clk = ~clk;

    learn_seq #(.SRCH_LAT(SRCH_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld_i), .cmd(cmd_i),
        .learn_sel(sel_i), .tbl_mode(mode_i), .nfa(nfa_i),
        .cmp_pair(cmp_pair), .cmp_even_data(cmp_e), .cmp_odd_data(cmp_o),
        .arr_we_even(we_e), .arr_we_odd(we_o), .arr_addr(aaddr),
        .arr_wdata_even(wde), .arr_wdata_odd(wdo), .nfa_upd(upd),
        .sram_addr(saddr), .sram_ce_n(sce_n), .sram_we_n(swe_n)
    );

    // Comparand register file contents (bit 0 of the base pattern is 0)
    function automatic logic [DW-1:0] cval(input logic [3:0] p, input logic odd, input logic [DW-1:0] s);
        return {p, 3'b101, odd, 60'h123456789ABCDE0} ^ s;
    endfunction

    always_comb begin
        cmp_e = cval(cmp_pair, 1'b0, salt);
        cmp_o = cval(cmp_pair, 1'b1, salt);
    end

    // ---------------- reference model ----------------
    int            ms = 0;
    logic [3:0]    m_idx = '0;
    logic [2:0]    m_hi = '0;
    logic          pend_upd = 1'b0;
    int            dueq[$];
    logic [SW-1:0] addrq[$];

    logic          e_we_e, e_we_o, e_upd, e_sce;
    logic [NW-1:0] e_addr;
    logic [DW-1:0] e_wde, e_wdo;
    logic [SW-1:0] e_saddr;
    logic [3:0]    e_pair;

    task automatic chk(input string sig, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (phase %s) %s: actual %h expected %h at cycle %0d", rq, phase, sig, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        logic [NW-1:0] a;
        cyc++;
        e_we_e = 1'b0; e_we_o = 1'b0; e_addr = '0; e_wde = '0; e_wdo = '0;
        if (!rst_n) begin
            ms = 0; m_idx = '0; m_hi = '0; pend_upd = 1'b0;
            dueq.delete(); addrq.delete();
            e_upd = 1'b0;
        end else begin
            e_upd = pend_upd;
            pend_upd = 1'b0;
            case (ms)
                0: if (cmd_vld_i && cmd_i[1:0] == 2'b11) begin
                    m_idx = cmd_i[5:2];
                    m_hi  = cmd_i[8:6];
                    ms = 1;
                end
                1: if (cmd_vld_i && cmd_i[1:0] == 2'b11 && cmd_i[5:2] == m_idx) begin
                    ms = 2;
                    if (sel_i && !mode_i[1]) begin
                        a = cmd_i[6] ? (nfa_i & ~NW'(1)) : nfa_i;
                        e_we_e = 1'b1;
                        e_we_o = cmd_i[6];
                        e_addr = a;
                        e_wde  = cval(m_idx, 1'b0, salt) | DW'(1);
                        e_wdo  = cmd_i[6] ? (cval(m_idx, 1'b1, salt) | DW'(1)) : '0;
                        pend_upd = 1'b1;
                        dueq.push_back(cyc + SRCH_LAT - 1);
                        addrq.push_back({m_hi, 5'b0, a});
                    end
                end else begin
                    ms = 0;
                end
                default: ms = 0;
            endcase
        end
        e_pair = m_idx;
        e_sce = 1'b1;
        e_saddr = '0;
        if (dueq.size() > 0 && dueq[0] == cyc) begin
            e_sce = 1'b0;
            e_saddr = addrq[0];
            void'(dueq.pop_front());
            void'(addrq.pop_front());
        end
        #(CLK_P/4);
        chk("arr_we_even",    "R2", DW'(we_e),  DW'(e_we_e));
        chk("arr_we_odd",     "R3", DW'(we_o),  DW'(e_we_o));
        chk("arr_addr",       "R2", DW'(aaddr), DW'(e_addr));
        chk("arr_wdata_even", "R2", wde, e_wde);
        chk("arr_wdata_odd",  "R3", wdo, e_wdo);
        chk("nfa_upd",        "R5", DW'(upd),   DW'(e_upd));
        chk("sram_ce_n",      "R6", DW'(sce_n), DW'(e_sce));
        chk("sram_we_n",      "R6", DW'(swe_n), DW'(e_sce));
        chk("sram_addr",      "R6", DW'(saddr), DW'(e_saddr));
        chk("cmp_pair",       "R4", DW'(cmp_pair), DW'(e_pair));
    end

    // ---------------- stimulus ----------------
    task automatic drv(input logic v, input logic [8:0] c);
        cmd_vld_i = v;
        cmd_i = c;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(1'b0, 9'h000);
    endtask

    task automatic learn(input logic [3:0] p, input logic [2:0] hi, input logic wide,
                         input logic sel, input logic [1:0] mode, input logic [NW-1:0] nv,
                         input string tg);
        phase = tg; sel_i = sel; mode_i = mode; nfa_i = nv;
        drv(1'b1, {hi, p, 2'b11});
        drv(1'b1, {2'b10, wide, p, 2'b11});
        drv(1'b0, 9'h1F0);
    endtask

    initial begin
        @(negedge clk);
        idle(3);                                  // R1: reset state observed
        rst_n = 1'b1;
        idle(2);                                  // R1: idle after release

        salt = 68'h0_0000_0000_0000_0000;
        learn(4'd3, 3'd5, 1'b0, 1'b1, 2'b00, 14'h0123, "R2");
        idle(SRCH_LAT + 2);
        salt = 68'hF_0F0F_0000_FFFF_0001;
        learn(4'd12, 3'd7, 1'b0, 1'b1, 2'b01, 14'h3FFF, "R2");
        idle(SRCH_LAT + 2);

        salt = 68'hA_5555_AAAA_1234_0000;
        learn(4'd7, 3'd2, 1'b1, 1'b1, 2'b01, 14'h0457, "R3");
        idle(SRCH_LAT + 2);
        learn(4'd15, 3'd7, 1'b1, 1'b1, 2'b01, 14'h3FFF, "R3");
        idle(SRCH_LAT + 2);
        learn(4'd0, 3'd0, 1'b1, 1'b1, 2'b00, 14'h0000, "R4");
        idle(SRCH_LAT + 2);

        learn(4'd9, 3'd1, 1'b0, 1'b1, 2'b10, 14'h0010, "R7");
        idle(SRCH_LAT + 2);
        learn(4'd9, 3'd1, 1'b1, 1'b1, 2'b11, 14'h0011, "R7");
        idle(SRCH_LAT + 2);
        learn(4'd6, 3'd4, 1'b0, 1'b0, 2'b00, 14'h0200, "R8");
        idle(SRCH_LAT + 2);

        // R9: malformed second cycles, each followed at once by a good learn
        phase = "R9"; sel_i = 1'b1; mode_i = 2'b00; nfa_i = 14'h0077;
        drv(1'b1, {3'd5, 4'd3, 2'b11});
        drv(1'b1, {3'd0, 4'd3, 2'b10});
        learn(4'd2, 3'd6, 1'b0, 1'b1, 2'b00, 14'h0078, "R9");
        idle(SRCH_LAT + 2);
        phase = "R9";
        drv(1'b1, {3'd5, 4'd3, 2'b11});
        drv(1'b1, {3'd1, 4'd4, 2'b11});
        learn(4'd4, 3'd3, 1'b1, 1'b1, 2'b01, 14'h0101, "R9");
        idle(SRCH_LAT + 2);
        phase = "R9";
        drv(1'b1, {3'd5, 4'd3, 2'b11});
        drv(1'b0, {3'd0, 4'd3, 2'b11});
        idle(SRCH_LAT + 2);

        // R10: non-learn opcodes while idle, and a learn presented in cycle 2
        phase = "R10";
        drv(1'b1, {3'd1, 4'd2, 2'b01});
        drv(1'b1, {3'd1, 4'd2, 2'b10});
        drv(1'b1, {3'd1, 4'd2, 2'b00});
        idle(2);
        nfa_i = 14'h0222;
        drv(1'b1, {3'd2, 4'd8, 2'b11});
        drv(1'b1, {2'b00, 1'b0, 4'd8, 2'b11});
        drv(1'b1, {3'd3, 4'd9, 2'b11});
        drv(1'b1, {3'd3, 4'd9, 2'b10});
        idle(SRCH_LAT + 2);

        // R11: back-to-back learns overlapping in the SRAM delay line
        learn(4'd1, 3'd1, 1'b0, 1'b1, 2'b00, 14'h1000, "R11");
        learn(4'd2, 3'd2, 1'b1, 1'b1, 2'b01, 14'h1003, "R11");
        learn(4'd3, 3'd3, 1'b0, 1'b1, 2'b00, 14'h1004, "R11");
        learn(4'd4, 3'd4, 1'b0, 1'b0, 2'b00, 14'h1005, "R11");
        learn(4'd5, 3'd6, 1'b1, 1'b1, 2'b01, 14'h2007, "R11");
        idle(SRCH_LAT + 4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule